// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block sequences one analog-to-digital conversion by binary search. A start pulse accepted while the block is idle launches a conversion. The block then resolves the code one bit at a time, beginning with the most significant bit. For each bit it raises that bit in its working word and presents the word to an external DAC. It then waits a fixed number of clock cycles so the DAC output and the comparator can settle. In the last cycle of the trial it samples the comparator and either keeps or drops the bit.

After all bits are resolved, one extra cycle registers the final code on `result`. `done` pulses for one cycle in that same cycle. `busy` frames the whole conversion. The comparator input is high when the analog input is at least the DAC test voltage.

The result port has no back-pressure. It is a plain registered value, and `done` marks the cycle in which a new value appears. A consumer that needs the value later can read it until the next conversion completes, because it does not change before then.

Top module: `sar_ctrl`

## Requirements
- R1: While reset is asserted (active low) and in the first cycle after it, `busy`, `done`, `result` and `dac_code` are all zero.
- R2: A `start` high at a clock edge while `busy` is low begins a conversion. From the next cycle `busy` is high, and `dac_code` holds only its most significant bit set.
- R3: Trial k (k = 0 for the MSB) drives a word on `dac_code` for SETTLE+1 cycles. In that word the bits above bit WIDTH-1-k equal the already decided bits, bit WIDTH-1-k is 1, and all lower bits are 0.
- R4: The comparator is sampled only in the last cycle of each trial, after SETTLE settle cycles. A sample taken earlier can see an unsettled value.
- R5: A tested bit stays 1 if `cmp_in` is 1 at its decision edge and is cleared otherwise. For an ideal comparator, the final `result` therefore equals the largest code not above the input (for 6 bits and input code 38, the trial words are 100000, 110000, 101000, 100100, 100110 and 100111, and the result is 100110).
- R6: `done` is high for exactly one cycle, WIDTH*(SETTLE+1)+1 edges after the start edge. `busy` falls at that same edge.
- R7: `result` changes only in a cycle where `done` is high. It stays stable throughout the next conversion.
- R8: A `start` that is high while `busy` is high is ignored. The conversion in progress keeps its timing and words.
- R9: A `start` that is high in the cycle where `done` is high is accepted, and the next conversion begins at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion request, sampled while idle |
| cmp_in | input | 1 | Comparator: 1 when the analog input is at least the DAC voltage |
| dac_code | output | WIDTH | Trial word driven to the DAC |
| result | output | WIDTH | Last completed conversion code |
| busy | output | 1 | High from the cycle after start until done |
| done | output | 1 | One-cycle pulse when a new result is presented |

## Verification
Two events can fall in the same cycle: the completion pulse of one conversion and the acceptance of the next start. The bench provokes this by driving `start` in the exact cycle `done` is high, with a new input code. It then judges the overlap by requiring, in the next cycle, that `busy` is high again, that the first trial word is the MSB alone, and that the old result is still held. The second conversion must then finish with its own code on the same schedule. A related case also falls in the bench's checks: random start pulses during the final register cycle, where `busy` is still high, must be ignored.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_DECIDE = 2'd2,
    ST_WRAP   = 2'd3
  } sar_state_e;
endpackage

// File: rtl/sar_settle_timer.sv
module sar_settle_timer #(
  parameter int SETTLE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  generate
    if (SETTLE == 0) begin : g_none
      logic unused_tmr;
      assign unused_tmr = ^{clk, rst_n, clear, run};
      assign expired = 1'b1;
    end else begin : g_count
      localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
      localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (run && cnt != LAST) cnt <= cnt + 1'b1;
      end

      assign expired = run && (cnt == LAST);

      // R4
      settle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= LAST));
      // R4
      settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !expired && !clear) |=> (cnt != '0));
    end
  endgenerate
endmodule

// File: rtl/sar_bit_pointer.sv
module sar_bit_pointer #(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  output logic [WIDTH-1:0] ptr,
  output logic             last
);
  localparam logic [WIDTH-1:0] TOP = {1'b1, {(WIDTH-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n)     ptr <= '0;
    else if (load)  ptr <= TOP;
    else if (shift) ptr <= ptr >> 1;
  end

  assign last = ptr[0];

  // R3
  ptr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ptr));
  // R3
  ptr_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load && !last) |=> $countones(ptr) == 1);
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             decide,
  input  logic             cmp,
  input  logic [WIDTH-1:0] ptr,
  output logic [WIDTH-1:0] approx
);
  localparam logic [WIDTH-1:0] TOP = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] kept;
  logic [WIDTH-1:0] hold_mask;

  always_comb begin
    kept      = cmp ? approx : (approx & ~ptr);
    hold_mask = ~((ptr << 1) - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      approx <= '0;
    else if (load)   approx <= TOP;
    else if (decide) approx <= kept | (ptr >> 1);
  end

  // R3
  upper_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && !load) |=> ((approx ^ $past(approx)) & $past(hold_mask)) == '0);
  // R5
  keep_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && !load && cmp) |=> ((approx & $past(ptr)) != '0));
  // R5
  drop_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && !load && !cmp) |=> ((approx & $past(ptr)) == '0));
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH  = 10,
  parameter int SETTLE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmp_in,
  output logic [WIDTH-1:0] dac_code,
  output logic [WIDTH-1:0] result,
  output logic             busy,
  output logic             done
);
  localparam logic [WIDTH-1:0] TOP = {1'b1, {(WIDTH-1){1'b0}}};

  sar_state_e       state_q, state_d;
  logic             load, decide, expired, ptr_last;
  logic [WIDTH-1:0] ptr, approx;

  assign load   = (state_q == ST_IDLE) && start;
  assign decide = (state_q == ST_DECIDE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start) state_d = (SETTLE == 0) ? ST_DECIDE : ST_SETTLE;
      ST_SETTLE: if (expired) state_d = ST_DECIDE;
      ST_DECIDE: begin
        if (ptr_last)         state_d = ST_WRAP;
        else if (SETTLE == 0) state_d = ST_DECIDE;
        else                  state_d = ST_SETTLE;
      end
      ST_WRAP:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      result  <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= (state_q == ST_WRAP);
      if (state_q == ST_WRAP) result <= approx;
    end
  end

  sar_settle_timer #(.SETTLE(SETTLE)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(load | decide),
    .run(state_q == ST_SETTLE), .expired(expired)
  );

  sar_bit_pointer #(.WIDTH(WIDTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(decide),
    .ptr(ptr), .last(ptr_last)
  );

  sar_approx_reg #(.WIDTH(WIDTH)) u_sar (
    .clk(clk), .rst_n(rst_n), .load(load), .decide(decide),
    .cmp(cmp_in), .ptr(ptr), .approx(approx)
  );

  assign dac_code = approx;
  assign busy     = (state_q != ST_IDLE);

  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && dac_code == TOP));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy || $past(done) == 1'b0);
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
  // R8
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state_q != ST_WRAP) |=> busy);
endmodule

// File: tb/sar_ctrl_bench.sv
module sar_ctrl_bench;
  localparam int W          = 6;
  localparam int S          = 2;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = W * (S + 1) + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         cmp_in;
  logic [W-1:0] dac_code, result;
  logic         busy, done;

  int           vin = 0;
  int           age = 0;
  logic [W-1:0] last_dac = '0;
  int           n_vec = 0;
  int           n_bad = 0;
  bit           finished = 0;

  sar_ctrl #(.WIDTH(W), .SETTLE(S)) u_sar_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_in(cmp_in),
    .dac_code(dac_code), .result(result), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Comparator model: wrong answer until the DAC word has been stable long enough.
  always @(negedge clk) begin
    if (dac_code !== last_dac) age = 1;
    else if (age < 1000) age = age + 1;
    last_dac = dac_code;
  end
  assign cmp_in = (age > S) ? (vin >= int'(dac_code)) : (vin < int'(dac_code));

  function automatic int trial_word(int v, int k);
    int lowmask = (1 << (W - k)) - 1;
    return (v & ~lowmask & ((1 << W) - 1)) | (1 << (W - 1 - k));
  endfunction

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic track(int v, bit chain, int vnext, bit spam);
    int prev = int'(result);
    for (int c = 0; c <= LAT; c++) begin
      if (c > 0) begin
        @(posedge clk);
        @(negedge clk);
      end
      start = 1'b0;
      if (c < W * (S + 1) && (c % (S + 1)) == 0)
        chk("R3", int'(dac_code), trial_word(v, c / (S + 1)));
      if (c == 0) chk("R2", int'(busy), 1);
      else        chk("R6", int'(busy), (c < LAT) ? 1 : 0);
      chk("R6", int'(done), (c == LAT) ? 1 : 0);
      if (c < LAT) chk("R7", int'(result), prev);
      else         chk("R5 (R4)", int'(result), v);
      if (spam && c >= 1 && c < LAT) start = ($urandom % 3) == 0; // R8
      if (c == LAT && chain) begin
        vin   = vnext;
        start = 1'b1;
      end
    end
    if (chain) begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk("R9", int'(busy), 1);
    end
  endtask

  task automatic launch(int v, bit chain, int vnext, bit spam);
    vin   = v;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    track(v, chain, vnext, spam);
  endtask

  initial begin
    int a;
    int b;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", int'(busy), 0);
    chk("R1", int'(done), 0);
    chk("R1", int'(result), 0);
    chk("R1", int'(dac_code), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(busy) + int'(done) + int'(result) + int'(dac_code), 0);

    launch(38, 0, 0, 0);
    launch(0, 0, 0, 0);
    launch((1 << W) - 1, 0, 0, 0);
    launch(1 << (W - 1), 0, 0, 0);
    launch((1 << (W - 1)) - 1, 0, 0, 1);
    launch(1, 0, 0, 1);
    launch(21, 1, 50, 1);
    track(50, 0, 0, 0);

    for (int i = 0; i < 40; i++) begin
      a = int'($urandom % (1 << W));
      b = int'($urandom % (1 << W));
      if (($urandom % 4) == 0) begin
        launch(a, 1, b, 1);
        track(b, 0, 0, 1);
      end else begin
        launch(a, 0, 0, ($urandom % 2) == 1);
        repeat ($urandom % 3) @(negedge clk);
      end
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule